// File: doc/BRIEF.md
# Voltage Monitor Reset Sequencer

This block drives the active-low system reset of a chip from two inputs. One is a voltage-good bit that an external comparator produces. The other is a tick from a free-running time base. The voltage-good bit is first brought into the clock domain by a synchronizer chain. It then passes a dip filter, and only a level that has stayed put for a set number of clock cycles is accepted. From global reset until the filtered voltage first reads good, the system reset stays asserted.

Once the voltage is good, a power-on delay counts a fixed number of time-base ticks. This count is the same one the watchdog uses as its period. When the count completes, the block releases the system reset and raises a "watchdog allowed" level. In the same cycle it sends a one-cycle strobe, so that the downstream watchdog starts its first closed window from a cleared timer.

A qualified drop of the voltage overrides everything else. The reset is asserted at once, the forced-disable output for the enable logic goes high, and the watchdog permission is withdrawn. Watchdog clear pulses therefore have no effect until a fresh and complete power-on delay has run. If the voltage falls and recovers while the delay is running, the whole delay starts again.

Top module: `vmon_rst_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `sys_rst_n_o`=0, `wd_allow_o`=0, `force_dis_o`=1 and `por_done_o`=0.
- R2: While the filtered voltage-good level is low, the system reset stays asserted, however many ticks arrive.
- R3: The delay counts only ticks that arrive after the voltage has been qualified good. Qualification happens SYNC_STAGES+FILT_CYCLES clock edges after `vgood_i` rises, and the state moves on one edge later.
- R4: The system reset is released at the clock edge that samples the POR_TICKS-th counted tick, and not before it. `por_done_o` is high for exactly that one cycle.
- R5: A low dip on `vgood_i` shorter than FILT_CYCLES clock cycles changes no output. During the delay it also leaves the tick count intact.
- R6: A low period of `vgood_i` lasting at least FILT_CYCLES cycles asserts the system reset SYNC_STAGES+FILT_CYCLES+1 clock edges after the fall. In the same cycle `force_dis_o` goes to 1 and `wd_allow_o` goes to 0.
- R7: A qualified drop during the delay discards the ticks already counted. After recovery, a full POR_TICKS new ticks are needed.
- R8: After a qualified drop from the released state, release again needs a full POR_TICKS ticks after recovery, and `por_done_o` pulses once more.
- R9: `wd_allow_o` equals `sys_rst_n_o`, and `force_dis_o` is its complement, at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low global reset |
| tick_i | input | 1 | One-cycle pulse from the time base |
| vgood_i | input | 1 | Voltage-good level from the comparator, not yet synchronized |
| sys_rst_n_o | output | 1 | Active-low system reset |
| wd_allow_o | output | 1 | High while the watchdog may act on clear pulses |
| force_dis_o | output | 1 | High while the enable logic must be held inactive |
| por_done_o | output | 1 | One-cycle strobe when the power-on delay completes |

## Verification
The bench builds the block with POR_TICKS=8, FILT_CYCLES=4 and SYNC_STAGES=2. A full power-on delay therefore takes only a few dozen cycles, so the bench can repeat it many times: after drops from the released state and after drops part way through the delay. Random dip lengths fall on both sides of the four-cycle filter threshold. The bench exercises the exact-threshold dip and the dip one cycle short of it directly. It also checks that release happens at exactly the eighth tick, and that the seventh tick does not release.

// File: rtl/vmon_pkg.sv
// Shared types for the voltage monitor reset sequencer.
package vmon_pkg;
    // Sequencer phases: supply bad, power-on delay running, released.
    typedef enum logic [1:0] {
        SEQ_OFF   = 2'd0,
        SEQ_DELAY = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/vmon_sync.sv
// vmon_sync: chain of STAGES flops that brings an asynchronous level into
// the clk domain. Assumes the input is a slow level, not a pulse.
module vmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= d_i;
            end
        end else begin : g_next
            // Later stages take the stage before them.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/vmon_filter.sv
// vmon_filter: accepts a new input level only after it has differed from
// the current accepted level for FILT_CYCLES consecutive cycles, so that
// shorter glitches are dropped. Assumes s_i is already synchronous.
module vmon_filter #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_i,
    output logic vok_o
);
    localparam int FW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
    localparam logic [FW-1:0] LAST = FW'(FILT_CYCLES - 1);

    logic [FW-1:0] run_q;

    // Count consecutive disagreeing cycles and flip the level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            vok_o <= 1'b0;
        end else if (s_i == vok_o) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q <= '0;
            vok_o <= s_i;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // A fall of the accepted level requires a low input at that edge.
    assert_fall_needs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vok_o) |-> !$past(s_i));
    // A rise of the accepted level requires a high input at that edge.
    assert_rise_needs_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vok_o) |-> $past(s_i));
endmodule

// File: rtl/vmon_por_timer.sv
// vmon_por_timer: counts time-base ticks while enabled. expire_o is high
// in the cycle in which the POR_TICKS-th tick is present. Clearing
// discards the count at once.
module vmon_por_timer #(
    parameter int POR_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CW = (POR_TICKS < 2) ? 1 : $clog2(POR_TICKS);
    localparam logic [CW-1:0] LAST = CW'(POR_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Advance on each tick, wrap at the period, zero while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (tick_i)       cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign expire_o = !clear_i && tick_i && (cnt_q == LAST);

    // The count never reaches the period itself.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // A clear leaves the count at zero on the next cycle.
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/vmon_rst_seq.sv
// vmon_rst_seq: system reset sequencer. Holds reset low until the filtered
// voltage-good level is high, waits POR_TICKS ticks, then releases reset
// and permits the watchdog. A qualified voltage drop returns it to the
// off phase from any state. Assumes tick_i is a single-cycle pulse.
module vmon_rst_seq #(
    parameter int POR_TICKS   = 100,
    parameter int FILT_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic vgood_i,
    output logic sys_rst_n_o,
    output logic wd_allow_o,
    output logic force_dis_o,
    output logic por_done_o
);
    import vmon_pkg::*;

    logic       vs_sync;
    logic       vok;
    logic       expire;
    seq_state_t state_q;

    vmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (vgood_i),
        .q_o   (vs_sync)
    );

    vmon_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .s_i   (vs_sync),
        .vok_o (vok)
    );

    vmon_por_timer #(.POR_TICKS(POR_TICKS)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (state_q != SEQ_DELAY),
        .tick_i   (tick_i),
        .expire_o (expire)
    );

    // Phase sequencing: a voltage drop wins over every other condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SEQ_OFF;
            por_done_o <= 1'b0;
        end else begin
            por_done_o <= 1'b0;
            if (!vok) begin
                state_q <= SEQ_OFF;
            end else begin
                case (state_q)
                    SEQ_OFF:   state_q <= SEQ_DELAY;
                    SEQ_DELAY: if (expire) begin
                                   state_q    <= SEQ_RUN;
                                   por_done_o <= 1'b1;
                               end
                    default:   state_q <= SEQ_RUN;
                endcase
            end
        end
    end

    assign sys_rst_n_o = (state_q == SEQ_RUN);
    assign wd_allow_o  = (state_q == SEQ_RUN);
    assign force_dis_o = (state_q != SEQ_RUN);

    // A fall of the filtered level asserts reset on the following edge.
    assert_drop_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vok) |=> !sys_rst_n_o);
    // A settled bad level keeps reset asserted.
    assert_stay_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!vok && !$past(vok)) |-> !sys_rst_n_o);
    // Release only happens on a tick, together with the strobe.
    assert_release_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n_o) |-> ($past(tick_i) && por_done_o));
    // The strobe lasts a single cycle.
    assert_pulse_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        por_done_o |=> !por_done_o);
endmodule

// File: tb/vmon_rst_seq_tb_top.sv
// Self-checking bench for vmon_rst_seq with small parameters.
module vmon_rst_seq_tb_top;
    localparam int POR = 8;
    localparam int FILT = 4;
    localparam int SYNC = 2;
    localparam int LAT = SYNC + FILT + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic vgood_i = 1'b0;
    logic sys_rst_n_o, wd_allow_o, force_dis_o, por_done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vmon_rst_seq #(.POR_TICKS(POR), .FILT_CYCLES(FILT), .SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .vgood_i(vgood_i),
        .sys_rst_n_o(sys_rst_n_o), .wd_allow_o(wd_allow_o),
        .force_dis_o(force_dis_o), .por_done_o(por_done_o)
    );

    // Expected {rst_n, allow, dis, done} for a released state and strobe.
    function automatic logic [3:0] exp_out(input bit rel, input bit pulse);
        return {rel, rel, !rel, pulse};
    endfunction

    function automatic bit dip_qualifies(input int len);
        return len >= FILT;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {sys_rst_n_o, wd_allow_o, force_dis_o, por_done_o};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic give_tick();
        tick_i = 1'b1; cyc(1); tick_i = 1'b0;
    endtask

    // Raise the supply, wait for qualification, then run the delay.
    task automatic power_up(input string tag);
        vgood_i = 1'b1;
        cyc(LAT + 2);
        for (int i = 0; i < POR - 1; i++) begin
            give_tick(); cyc(1);
            chk(tag, exp_out(0, 0));
        end
        give_tick();
        chk(tag, exp_out(1, 1));
        cyc(1);
        chk(tag, exp_out(1, 0));
    endtask

    // Low pulse of len cycles from the released state.
    task automatic dip_in_run(input int len, input string tag);
        vgood_i = 1'b0;
        for (int i = 1; i <= LAT + len + 2; i++) begin
            cyc(1);
            if (i == len) vgood_i = 1'b1;
            if (dip_qualifies(len)) begin
                if (i == LAT - 1) chk({tag, " R6 before"}, exp_out(1, 0));
                if (i == LAT)     chk({tag, " R6"}, exp_out(0, 0));
            end else begin
                chk({tag, " R5"}, exp_out(1, 0));
            end
        end
        vgood_i = 1'b1;
        if (dip_qualifies(len)) begin
            cyc(LAT + 2);
            power_up({tag, " R8"});
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        cyc(2);
        chk("R1 in reset", exp_out(0, 0));
        rst_n = 1'b1;
        cyc(1);
        chk("R1 after reset", exp_out(0, 0));

        // R2: ticks with the supply bad are ignored.
        for (int i = 0; i < 2 * POR; i++) begin
            give_tick(); cyc(1);
            chk("R2 supply low", exp_out(0, 0));
        end

        // R3: ticks during qualification do not count.
        vgood_i = 1'b1;
        for (int i = 0; i < LAT - 1; i++) begin
            tick_i = 1'b1; cyc(1);
            chk("R3 qualifying", exp_out(0, 0));
        end
        tick_i = 1'b0;
        cyc(1);
        chk("R3 delay started", exp_out(0, 0));
        power_up("R4 first");

        // R5 and R6: threshold cases, then random lengths.
        dip_in_run(FILT - 1, "dip short");
        dip_in_run(FILT, "dip exact");
        dip_in_run(1, "dip single");
        for (int k = 0; k < 20; k++) begin
            dip_in_run(int'($urandom_range(1, FILT + 3)), "dip random");
        end

        // R5: short dip during the delay keeps the count.
        vgood_i = 1'b0; cyc(LAT + 4);
        vgood_i = 1'b1; cyc(LAT + 2);
        for (int i = 0; i < 3; i++) begin give_tick(); cyc(1); end
        vgood_i = 1'b0; cyc(FILT - 1); vgood_i = 1'b1; cyc(LAT + 2);
        for (int i = 0; i < POR - 4; i++) begin
            give_tick(); cyc(1);
            chk("R5 delay dip", exp_out(0, 0));
        end
        give_tick();
        chk("R5 delay dip release", exp_out(1, 1));
        cyc(1);

        // R7: qualified drop during the delay restarts it.
        vgood_i = 1'b0; cyc(LAT + 4);
        vgood_i = 1'b1; cyc(LAT + 2);
        for (int i = 0; i < POR - 2; i++) begin give_tick(); cyc(1); end
        vgood_i = 1'b0; cyc(FILT + 2); vgood_i = 1'b1; cyc(LAT + 2);
        chk("R7 after drop", exp_out(0, 0));
        power_up("R7 full restart");

        // R9 is covered by every exp_out comparison above.
        chk("R9 final", exp_out(1, 0));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule